// File: doc/BRIEF.md
# Mixed-Length Instruction Prefetch Buffer

The block sits between a 32-bit instruction fetch port and a decode stage that accepts both 16-bit and 32-bit instructions. It fetches word-aligned 32-bit words and splits them into halfwords. It keeps up to three halfwords in a small queue and gives decode one complete instruction per cycle. A 32-bit instruction that starts in the upper half of one word and ends in the lower half of the next is joined from the two fetches. Decode does not wait for it to be realigned.

Data returned by the bus in a cycle can be handed straight to decode in that same cycle, so the queue adds no pipeline stage. A redirect input carries a new target address. In that cycle the block empties the queue, restarts fetching at the target's word and drops any word already on its way back. The block keeps its own fetch pointer and the address of the instruction it is presenting. It stops requesting words once the queue could not hold another one.

Top module: `instr_prefetch_buf`

## Requirements
- R1: A first halfword whose bits [15:11] are 11101, 11110 or 11111 starts a 32-bit instruction. `decInstr` then holds the first halfword in [31:16] and the following halfword in [15:0], and `decIs32` is 1. Any other first halfword is a 16-bit instruction: it is returned zero-extended in [15:0] and `decIs32` is 0.
- R2: Each fetch address is word aligned. Consecutive fetches advance by 4. Within a returned word, bits [15:0] are the halfword at the lower address.
- R3: `decValid` is 1 exactly when every halfword of the head instruction is available. A halfword counts as available if it is in the queue or arrives on `rspData` in the same cycle.
- R4: A 32-bit instruction whose first halfword is at an address with bit 1 set is built from the upper half of one word and the lower half of the next.
- R5: At most one fetch is outstanding. A request is raised only when no word is outstanding, or when one returns in the same cycle, and the queue will hold at most one halfword after this cycle. A request that is not granted keeps its address until it is granted or a redirect arrives.
- R6: The queue never holds more than three halfwords.
- R7: When decode accepts an instruction (`decValid` and `decReady`), `decPc` advances by 2 for a 16-bit instruction and by 4 for a 32-bit one.
- R8: In a redirect cycle `decValid` is 0 and the queue is emptied. In the next cycle `decPc` equals the target with bit 0 cleared. The fetch address in the redirect cycle is the word that holds the target.
- R9: If the target has bit 1 set, the lower halfword of the first word returned after the redirect is discarded.
- R10: A word returned for a fetch that was outstanding when a redirect arrived is dropped. So is any word that returns in the redirect cycle itself.
- R11: During and right after reset, `decValid` is 0, `decPc` equals `RESET_ADDR`, and the first fetch is from `RESET_ADDR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| redirValid | input | 1 | Redirect: flush and restart at `redirAddr` |
| redirAddr | input | ADDR_W | Redirect target, halfword aligned |
| fetchReq | output | 1 | Fetch request |
| fetchAddr | output | ADDR_W | Word-aligned fetch address |
| fetchGnt | input | 1 | Request accepted when high together with `fetchReq` |
| rspValid | input | 1 | Fetched word returning this cycle |
| rspData | input | 32 | Fetched word, lower address in [15:0] |
| decValid | output | 1 | A complete instruction is presented |
| decReady | input | 1 | Decode takes the presented instruction |
| decInstr | output | 32 | Presented instruction |
| decIs32 | output | 1 | Presented instruction is 32 bits long |
| decPc | output | ADDR_W | Address of the presented instruction |

## Verification
Some properties are checked by assertions on every cycle:
- the occupancy bound;
- the 2/4 step of the instruction address on each accepted instruction;
- the address loaded by a redirect;
- that a request which is not granted holds its address;
- that a discarded lower half only happens when the head sits at an odd halfword.

Other behaviour only appears over sequences that the bench sets up:
- the same-cycle handoff of returning data;
- the join of straddling instructions;
- the exact number of words fetched while decode is stalled after an aligned or an odd-halfword redirect;
- dropping a stale word that returns after a second redirect.

The bench also compares every output against its own halfword-count model on every cycle.

// File: rtl/ipb_pkg.sv
package ipb_pkg;

  localparam int HALF_W = 16;

  typedef logic [HALF_W-1:0] half_t;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;    // redirect this cycle
    logic takeRsp;  // returning word is live and enters the view
    logic dropLow;  // discard lower halfword of the returning word
  } strobe_t;

  // prefixes 11101, 11110, 11111 mark a long instruction
  function automatic logic isLongHead(half_t h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction

endpackage

// File: rtl/ipb_ctrl.sv
module ipb_ctrl
  import ipb_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             redirValid,
  input  logic             redirOddHalf,
  input  logic             rspValid,
  input  logic             fetchGnt,
  input  logic [CNT_W-1:0] nextCount,
  output strobe_t          strb,
  output logic             fetchReq,
  output logic             fetchFire
);

  logic inFlight;
  logic dropNext;
  logic skipLow;

  // a fresh word fits only if two slots are free after this cycle
  localparam logic [CNT_W-1:0] REQ_LIMIT = CNT_W'(DEPTH - 2);

  always_comb begin
    strb.flush   = redirValid;
    strb.takeRsp = rspValid && inFlight && !dropNext && !redirValid;
    strb.dropLow = skipLow;
    fetchReq     = (!inFlight || rspValid) && (nextCount <= REQ_LIMIT);
    fetchFire    = fetchReq && fetchGnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      dropNext <= 1'b0;
      skipLow  <= 1'b0;
    end else begin
      if (fetchFire)     inFlight <= 1'b1;
      else if (rspValid) inFlight <= 1'b0;

      if (fetchFire || rspValid)      dropNext <= 1'b0;
      else if (redirValid && inFlight) dropNext <= 1'b1;

      if (redirValid)        skipLow <= redirOddHalf;
      else if (strb.takeRsp) skipLow <= 1'b0;
    end
  end

  // R10: a word taken into the view always belongs to a live request
  assert_live_word_R10: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && inFlight && !rspValid) |=> (!strb.takeRsp));

endmodule

// File: rtl/ipb_datapath.sv
module ipb_datapath
  import ipb_pkg::*;
#(
  parameter int             ADDR_W     = 32,
  parameter int             DEPTH      = 3,
  parameter logic [31:0]    RESET_ADDR = 32'h0,
  localparam int            CNT_W      = $clog2(DEPTH + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              fetchFire,
  input  logic [ADDR_W-1:0] redirAddr,
  input  logic [31:0]       rspData,
  input  logic              decReady,
  output logic              decValid,
  output logic [31:0]       decInstr,
  output logic              decIs32,
  output logic [ADDR_W-1:0] decPc,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [CNT_W-1:0]  nextCount
);

  localparam int VIEW_N = DEPTH + 2;

  half_t             q     [DEPTH];
  half_t             qNext [DEPTH];
  half_t             view  [VIEW_N];
  half_t             inHw  [2];
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        inNum;
  logic [CNT_W-1:0]  avail;
  logic [1:0]        need;
  logic [1:0]        used;
  logic              decFire;
  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] fetchPtr;
  logic [ADDR_W-1:0] redirWord;

  assign redirWord = {redirAddr[ADDR_W-1:2], 2'b00};

  // incoming halfwords of this cycle
  always_comb begin
    inNum   = strb.takeRsp ? (strb.dropLow ? 2'd1 : 2'd2) : 2'd0;
    inHw[0] = strb.dropLow ? rspData[31:16] : rspData[15:0];
    inHw[1] = rspData[31:16];
  end

  // queued halfwords followed by the incoming ones
  always_comb begin
    for (int i = 0; i < VIEW_N; i++) begin
      view[i] = '0;
      if (i < int'(cnt)) begin
        view[i] = q[i % DEPTH];
      end else if (i - int'(cnt) == 0 && inNum != 2'd0) begin
        view[i] = inHw[0];
      end else if (i - int'(cnt) == 1 && inNum == 2'd2) begin
        view[i] = inHw[1];
      end
    end
  end

  always_comb begin
    avail     = cnt + CNT_W'(inNum);
    decIs32   = isLongHead(view[0]);
    need      = decIs32 ? 2'd2 : 2'd1;
    decValid  = !strb.flush && (avail >= CNT_W'(need));
    decFire   = decValid && decReady;
    used      = decFire ? need : 2'd0;
    nextCount = strb.flush ? '0 : (avail - CNT_W'(used));
    decInstr  = decIs32 ? {view[0], view[1]} : {16'h0000, view[0]};
    decPc     = pcQ;
    fetchAddr = strb.flush ? redirWord : fetchPtr;
  end

  // shift out consumed halfwords
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      case (used)
        2'd1:    qNext[i] = view[i + 1];
        2'd2:    qNext[i] = view[i + 2];
        default: qNext[i] = view[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      cnt <= nextCount;
      for (int i = 0; i < DEPTH; i++) q[i] <= qNext[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ      <= {RESET_ADDR[ADDR_W-1:1], 1'b0};
      fetchPtr <= {RESET_ADDR[ADDR_W-1:2], 2'b00};
    end else begin
      if (strb.flush)   pcQ <= {redirAddr[ADDR_W-1:1], 1'b0};
      else if (decFire) pcQ <= pcQ + (decIs32 ? ADDR_W'(4) : ADDR_W'(2));

      if (strb.flush)     fetchPtr <= redirWord + (fetchFire ? ADDR_W'(4) : ADDR_W'(0));
      else if (fetchFire) fetchPtr <= fetchPtr + ADDR_W'(4);
    end
  end

  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (decFire && !strb.flush) |=>
      (pcQ == $past(pcQ) + ($past(decIs32) ? ADDR_W'(4) : ADDR_W'(2))));

  assert_flush_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (pcQ == $past({redirAddr[ADDR_W-1:1], 1'b0})));

  assert_skip_align_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeRsp && strb.dropLow && cnt == '0) |-> pcQ[1]);

endmodule

// File: rtl/instr_prefetch_buf.sv
module instr_prefetch_buf
  import ipb_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DEPTH      = 3,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              redirValid,
  input  logic [ADDR_W-1:0] redirAddr,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchGnt,
  input  logic              rspValid,
  input  logic [31:0]       rspData,
  output logic              decValid,
  input  logic              decReady,
  output logic [31:0]       decInstr,
  output logic              decIs32,
  output logic [ADDR_W-1:0] decPc
);

  localparam int CNT_W = $clog2(DEPTH + 3);

  strobe_t          strb;
  logic             fetchFire;
  logic [CNT_W-1:0] nextCount;

  ipb_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .redirValid   (redirValid),
    .redirOddHalf (redirAddr[1]),
    .rspValid     (rspValid),
    .fetchGnt     (fetchGnt),
    .nextCount    (nextCount),
    .strb         (strb),
    .fetchReq     (fetchReq),
    .fetchFire    (fetchFire)
  );

  ipb_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fetchFire (fetchFire),
    .redirAddr (redirAddr),
    .rspData   (rspData),
    .decReady  (decReady),
    .decValid  (decValid),
    .decInstr  (decInstr),
    .decIs32   (decIs32),
    .decPc     (decPc),
    .fetchAddr (fetchAddr),
    .nextCount (nextCount)
  );

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchGnt && !redirValid) |=>
      (redirValid || (fetchReq && $stable(fetchAddr))));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (fetchAddr[1:0] == 2'b00));

endmodule

// File: tb/tb_instr_prefetch_buf.sv
module tb_instr_prefetch_buf;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        redirValid = 1'b0;
  logic [31:0] redirAddr = '0;
  logic        fetchReq;
  logic [31:0] fetchAddr;
  logic        fetchGnt = 1'b0;
  logic        rspValid = 1'b0;
  logic [31:0] rspData = '0;
  logic        decValid;
  logic        decReady = 1'b0;
  logic [31:0] decInstr;
  logic        decIs32;
  logic [31:0] decPc;

  always #2 clk = ~clk;  // 250 MHz

  instr_prefetch_buf dut (
    .clk(clk), .rstN(rstN), .redirValid(redirValid), .redirAddr(redirAddr),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchGnt(fetchGnt),
    .rspValid(rspValid), .rspData(rspData), .decValid(decValid),
    .decReady(decReady), .decInstr(decInstr), .decIs32(decIs32), .decPc(decPc)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  logic [31:0] mPc = '0, mFetch = '0, rAddr = '0;
  int  mCnt = 0, lat = 0, hsCount = 0, forceLat = -1;
  bit  busy = 0, stale = 0, skip = 0;
  int  straddle = 0, bypass = 0, staleDrop = 0;
  // drive controls
  int  readyPct = 0, gntPct = 100, redirPct = 0;

  function automatic logic [15:0] memHw(logic [31:0] a);
    logic [31:0] x;
    logic [15:0] h;
    x = ((a >> 1) * 32'h9E3779B1) ^ 32'h5BD1E995;
    h = x[31:16];
    if (x[9:8] == 2'b00)
      h[15:11] = (x[11:10] == 2'd0) ? 5'b11101 : (x[11:10] == 2'd1) ? 5'b11110 : 5'b11111;
    else if (h[15:13] == 3'b111)
      h[12:11] = 2'b00;
    return h;
  endfunction

  function automatic bit longH(logic [15:0] h);
    return h[15:11] == 5'b11101 || h[15:11] == 5'b11110 || h[15:11] == 5'b11111;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit forceRedir, logic [31:0] tgt);
    bit redirNow, rspNow, expV, expReq, hs;
    int inc, avail, need, used, after;
    logic [15:0] h0;
    logic [31:0] expInstr, tAddr;
    @(negedge clk);
    decReady = ($urandom_range(0, 99) < readyPct);
    fetchGnt = ($urandom_range(0, 99) < gntPct);
    tAddr = forceRedir ? tgt : {16'h0, 15'($urandom_range(0, 32767)), 1'b0};
    redirNow = forceRedir || ($urandom_range(0, 99) < redirPct);
    redirValid = redirNow;
    redirAddr = tAddr;
    rspNow = busy && lat == 0;
    rspValid = rspNow;
    rspData = rspNow ? {memHw(rAddr + 2), memHw(rAddr)} : $urandom;
    #1;
    inc = (rspNow && !stale && !redirNow) ? (skip ? 1 : 2) : 0;
    avail = mCnt + inc;
    h0 = memHw(mPc);
    need = longH(h0) ? 2 : 1;
    expV = !redirNow && avail >= need;
    chk(decValid == expV, redirNow ? "R8" : "R3", 32'(decValid), 32'(expV));
    if (decValid && expV) begin
      expInstr = (need == 2) ? {h0, memHw(mPc + 2)} : {16'h0, h0};
      chk(decPc == mPc, "R7", decPc, mPc);
      chk(decInstr == expInstr, (need == 2 && mPc[1]) ? "R4" : "R1", decInstr, expInstr);
      chk(decIs32 == (need == 2), "R1", 32'(decIs32), 32'(need == 2));
    end
    used = (expV && decReady) ? need : 0;
    after = redirNow ? 0 : avail - used;
    expReq = (!busy || rspNow) && after <= 1;
    chk(fetchReq == expReq, "R5", 32'(fetchReq), 32'(expReq));
    if (fetchReq)
      chk(fetchAddr == (redirNow ? {tAddr[31:2], 2'b00} : mFetch), redirNow ? "R8" : "R2",
          fetchAddr, redirNow ? {tAddr[31:2], 2'b00} : mFetch);
    if (used == 2 && mPc[1]) straddle++;
    if (expV && mCnt == 0 && inc > 0) bypass++;
    if (rspNow && stale && !redirNow) staleDrop++;
    if (redirNow) begin
      mCnt = 0; mPc = {tAddr[31:1], 1'b0}; mFetch = {tAddr[31:2], 2'b00}; skip = tAddr[1];
    end else begin
      mCnt = after; mPc = mPc + 32'(used * 2);
      if (inc > 0) skip = 0;
    end
    if (rspNow) busy = 0;
    else if (busy) lat--;
    if (redirNow && busy) stale = 1;
    hs = fetchReq && fetchGnt;
    if (hs) begin
      busy = 1; stale = 0; rAddr = fetchAddr; mFetch = fetchAddr + 4; hsCount++;
      lat = (forceLat >= 0) ? forceLat : $urandom_range(0, 3);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0);
  endtask

  initial begin : main
    int h0;
    // R11: reset state
    repeat (3) begin
      @(negedge clk); #1;
      chk(decValid == 1'b0, "R11", 32'(decValid), 0);
      chk(decPc == 32'h0, "R11", decPc, 0);
      chk(fetchAddr == 32'h0, "R11", fetchAddr, 0);
    end
    rstN = 1'b1;
    // decode stalled: aligned target brings one word (R5, R6)
    readyPct = 0; gntPct = 100;
    run(10);
    h0 = hsCount;
    step(1'b1, 32'h100);
    run(15);
    chk(hsCount - h0 == 1, "R5", 32'(hsCount - h0), 1);
    chk(decPc == 32'h100, "R8", decPc, 32'h100);
    // odd halfword target: lower half dropped, two words fill three slots (R9, R6)
    h0 = hsCount;
    step(1'b1, 32'h202);
    run(15);
    chk(hsCount - h0 == 2, "R9", 32'(hsCount - h0), 2);
    chk(decPc == 32'h202, "R9", decPc, 32'h202);
    // stale word after back-to-back redirects (R10)
    readyPct = 100; forceLat = 3;
    step(1'b1, 32'h300);
    step(1'b1, 32'h400);
    forceLat = -1;
    run(20);
    chk(staleDrop >= 1, "R10", 32'(staleDrop), 1);
    // random traffic
    readyPct = 70; gntPct = 70; redirPct = 2;
    run(4000);
    // full speed
    readyPct = 100; gntPct = 100; redirPct = 0;
    run(500);
    chk(straddle > 0, "R4", 32'(straddle), 1);
    chk(bypass > 0, "R3", 32'(bypass), 1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule